// File: doc/BRIEF.md
# Successive-Approximation Converter Control Core

This block is the digital controller of a successive-approximation analog-to-digital converter with a three-wire serial output. It waits for the active-low chip select to fall. That edge ends sampling and starts a self-timed conversion. During the conversion a binary search drives a DAC code word and reads a one-bit comparator, one trial bit at a time, starting at the most significant bit. When the search is done, the serial data pin goes high as an end-of-conversion flag. The result bits then follow, one per falling edge of an external serial clock. While chip select is high the data pin is released, which is modelled by dropping an output-enable.

An active-low shutdown input powers the block down. Leaving shutdown starts a wake-up interval, and no conversion can start until it has run out. All inputs are taken as synchronous to the system clock. Edges on chip select and on the serial clock are found by comparing each input with its value at the previous clock edge.

The controller has eight states. OFF is the shutdown state and the reset state. WAKE counts the wake-up interval. IDLE waits for a chip-select fall. SETUP counts the fixed overhead. TRIAL runs one step per result bit. EOC holds the end-of-conversion flag. SHIFT presents the result bits. TAIL drives low after the last bit. The transitions are these:
- Any state goes to OFF while shutdown is low.
- OFF goes to WAKE when shutdown is high.
- WAKE goes to IDLE when its count expires.
- IDLE goes to SETUP on a chip-select fall.
- SETUP goes to TRIAL when the overhead count expires.
- TRIAL goes to EOC after the last bit.
- EOC goes to SHIFT on the first serial-clock fall.
- SHIFT goes to TAIL on the fall after the last bit.
- SETUP, TRIAL, EOC, SHIFT and TAIL all go back to IDLE when chip select rises.

Top module: `sar_adc_core`

## Requirements
- R1: After reset, and for as long as shutdown_n is low, the block stays powered down. In that state dout_oe is 0, and chip-select activity starts nothing.
- R2: When shutdown_n rises at clock edge W0, the block enters WAKE at W0 and reaches IDLE at W0+WAKE_CYCLES. A chip-select fall is acted on only if it is first seen at edge W0+WAKE_CYCLES+1 or later. An earlier fall is ignored, and the block then waits for a fresh fall.
- R3: A chip-select fall seen in IDLE starts a conversion. From the next cycle, dout_oe is 1 and dout is 0 until end of conversion.
- R4: dout goes to 1 (the end-of-conversion flag) exactly CONV_CYCLES = OVERHEAD_CYCLES + WIDTH*STEP_CYCLES clock edges after the edge that saw the chip-select fall.
- R5: The trials run from the MSB down to the LSB, and each trial lasts STEP_CYCLES cycles. A trial ORs its bit into dac_code, then samples cmp_in in the trial's last cycle. cmp_in = 1 means the input is at or above the DAC value, and the bit is kept. cmp_in = 0 clears the bit. After the last trial, dac_code holds the result.
- R6: After end of conversion, the k-th serial-clock fall (k = 1..WIDTH) puts result bit WIDTH-k on dout, so the MSB comes first, in straight unsigned binary. dout updates one clock edge after the fall is seen.
- R7: The serial-clock fall after the LSB, and every later fall, drives dout to 0.
- R8: While the result is being read out, dout holds its value in every cycle in which no serial-clock fall is seen.
- R9: When cs_n is high at a clock edge, dout_oe is 0 after that edge.
- R10: If chip select rises during SETUP, TRIAL, EOC, SHIFT or TAIL, the block abandons the conversion and returns to IDLE. The next chip-select fall runs a complete, correct conversion.
- R11: Serial-clock falls seen before end of conversion are ignored. They do not change dout, dac_code or the order of the result bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shutdown_n | input | 1 | Active-low power-down request |
| cs_n | input | 1 | Active-low chip select; a falling edge starts a conversion |
| sclk | input | 1 | Serial clock; result bits advance on its falling edge |
| cmp_in | input | 1 | Comparator: 1 when the held input is at or above the DAC code |
| dac_code | output | WIDTH | Trial code for the DAC; holds the result after conversion |
| dout | output | 1 | Serial data: low, then the end-of-conversion flag, then the result bits |
| dout_oe | output | 1 | Drive enable for dout; 0 models high impedance |

## Verification
The bench builds the block with WIDTH=6, OVERHEAD_CYCLES=3, STEP_CYCLES=2 and WAKE_CYCLES=16. With these values every one of the 64 input codes can be converted and read back, against a comparator model that the bench computes from the DAC code. Short timers put the exact conversion latency and both sides of the wake-up boundary within a few cycles. That leaves room for aborted conversions and readouts, serial-clock noise during conversion, and shutdown periods in the same run.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_WAKE  = 3'd1,
        ST_IDLE  = 3'd2,
        ST_SETUP = 3'd3,
        ST_TRIAL = 3'd4,
        ST_EOC   = 3'd5,
        ST_SHIFT = 3'd6,
        ST_TAIL  = 3'd7
    } sar_state_t;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sar_timer.sv
module sar_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    AST_TMR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1)); // R4

endmodule

// File: rtl/sar_search.sv
module sar_search #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] code,
    output logic             last
);

    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] code_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] kept;
    logic [WIDTH-1:0] mask_nx;

    always_comb begin
        kept    = cmp_in ? code_q : (code_q & ~mask_q);
        mask_nx = mask_q >> 1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (start) begin
            code_q <= TOP_BIT;
            mask_q <= TOP_BIT;
        end else if (step && mask_q != '0) begin
            code_q <= kept | mask_nx;
            mask_q <= mask_nx;
        end
    end

    assign code = code_q;
    assign last = mask_q[0];

    AST_MASK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_q)); // R5
    AST_BIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && mask_q != '0 && cmp_in) |=> ((code_q & $past(mask_q)) != '0)); // R5
    AST_BIT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start && mask_q != '0 && !cmp_in) |=> ((code_q & $past(mask_q)) == '0)); // R5
    AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start) |=> (((code_q ^ $past(code_q)) & ~($past(mask_q) | ($past(mask_q) >> 1))) == '0)); // R5

endmodule

// File: rtl/sar_shifter.sv
module sar_shifter #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] data_in,
    output logic             bit_out,
    output logic             empty
);

    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] FULL = CW'(WIDTH);

    logic [CW-1:0] left_q;
    logic          bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
            bit_q  <= 1'b0;
        end else if (load) begin
            left_q <= FULL;
            bit_q  <= 1'b0;
        end else if (shift && left_q != '0) begin
            bit_q  <= data_in[left_q - 1'b1];
            left_q <= left_q - 1'b1;
        end
    end

    assign bit_out = bit_q;
    assign empty   = (left_q == '0);

    AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= FULL); // R6
    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(bit_q)); // R8

endmodule

// File: rtl/sar_adc_core.sv
module sar_adc_core
    import sar_pkg::*;
#(
    parameter int WIDTH           = 12,
    parameter int OVERHEAD_CYCLES = 66,
    parameter int STEP_CYCLES     = 32,
    parameter int WAKE_CYCLES     = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shutdown_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             cmp_in,
    output logic [WIDTH-1:0] dac_code,
    output logic             dout,
    output logic             dout_oe
);

    localparam int          CONV_CYCLES = OVERHEAD_CYCLES + WIDTH * STEP_CYCLES;
    localparam int unsigned TMAX = max3(WAKE_CYCLES, OVERHEAD_CYCLES, STEP_CYCLES);
    localparam int          TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] WAKE_LD = TW'(WAKE_CYCLES - 1);
    localparam logic [TW-1:0] OVH_LD  = TW'(OVERHEAD_CYCLES - 1);
    localparam logic [TW-1:0] STEP_LD = TW'(STEP_CYCLES - 1);

    sar_state_t state_q, state_nx;

    logic          cs_q, sclk_q;
    logic          cs_fall, sclk_fall;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          srch_start, srch_step, srch_last;
    logic          shf_load, shf_shift, shf_bit, shf_empty;

    // edge detection on the two externally timed inputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
        end
    end

    assign cs_fall   = cs_q & ~cs_n;
    assign sclk_fall = sclk_q & ~sclk;

    sar_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sar_search #(.WIDTH(WIDTH)) u_search (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (srch_start),
        .step   (srch_step),
        .cmp_in (cmp_in),
        .code   (dac_code),
        .last   (srch_last)
    );

    sar_shifter #(.WIDTH(WIDTH)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (shf_load),
        .shift   (shf_shift),
        .data_in (dac_code),
        .bit_out (shf_bit),
        .empty   (shf_empty)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_nx;
        end
    end

    // next state and datapath controls
    always_comb begin
        state_nx   = state_q;
        tmr_load   = 1'b0;
        tmr_val    = STEP_LD;
        srch_start = 1'b0;
        srch_step  = 1'b0;
        shf_load   = 1'b0;
        shf_shift  = 1'b0;
        if (!shutdown_n) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_nx = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = WAKE_LD;
                end
                ST_WAKE: begin
                    if (tmr_zero) begin
                        state_nx = ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (cs_fall) begin
                        state_nx   = ST_SETUP;
                        tmr_load   = 1'b1;
                        tmr_val    = OVH_LD;
                        srch_start = 1'b1;
                        shf_load   = 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (cs_n) begin
                        state_nx = ST_IDLE;
                    end else if (tmr_zero) begin
                        state_nx = ST_TRIAL;
                        tmr_load = 1'b1;
                        tmr_val  = STEP_LD;
                    end
                end
                ST_TRIAL: begin
                    if (cs_n) begin
                        state_nx = ST_IDLE;
                    end else if (tmr_zero) begin
                        srch_step = 1'b1;
                        if (srch_last) begin
                            state_nx = ST_EOC;
                        end else begin
                            tmr_load = 1'b1;
                            tmr_val  = STEP_LD;
                        end
                    end
                end
                ST_EOC: begin
                    if (cs_n) begin
                        state_nx = ST_IDLE;
                    end else if (sclk_fall) begin
                        state_nx  = ST_SHIFT;
                        shf_shift = 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (cs_n) begin
                        state_nx = ST_IDLE;
                    end else if (sclk_fall) begin
                        if (shf_empty) begin
                            state_nx = ST_TAIL;
                        end else begin
                            shf_shift = 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (cs_n) begin
                        state_nx = ST_IDLE;
                    end
                end
                default: state_nx = ST_OFF;
            endcase
        end
    end

    // outputs decoded from registered state
    always_comb begin
        dout    = 1'b0;
        dout_oe = 1'b0;
        unique case (state_q)
            ST_OFF, ST_WAKE, ST_IDLE: begin
                dout    = 1'b0;
                dout_oe = 1'b0;
            end
            ST_SETUP, ST_TRIAL, ST_TAIL: begin
                dout    = 1'b0;
                dout_oe = 1'b1;
            end
            ST_EOC: begin
                dout    = 1'b1;
                dout_oe = 1'b1;
            end
            ST_SHIFT: begin
                dout    = shf_bit;
                dout_oe = 1'b1;
            end
            default: begin
                dout    = 1'b0;
                dout_oe = 1'b0;
            end
        endcase
    end

    AST_CS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !dout_oe); // R9
    AST_SHDN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !shutdown_n |=> (state_q == ST_OFF && !dout_oe)); // R1
    AST_WAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE) |=> (state_q inside {ST_WAKE, ST_IDLE, ST_OFF})); // R2
    AST_EOC_FROM_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EOC && $past(state_q) != ST_EOC) |-> ($past(state_q) == ST_TRIAL)); // R4
    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_EOC, ST_SHIFT, ST_TAIL} && !sclk_fall && !cs_n && shutdown_n)
            |=> $stable(dout)); // R8
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_SETUP, ST_TRIAL, ST_EOC, ST_SHIFT, ST_TAIL} && cs_n && shutdown_n)
            |=> (state_q == ST_IDLE)); // R10

endmodule

// File: tb/tb_sar_adc_core.sv
module tb_sar_adc_core;

    localparam int CLK_PERIOD = 10;
    localparam int W    = 6;
    localparam int OVH  = 3;
    localparam int STEP = 2;
    localparam int WAKE = 16;
    localparam int CONV = OVH + W * STEP;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shutdown_n = 1'b1;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b1;
    logic         cmp_in;
    logic [W-1:0] dac_code;
    logic         dout;
    logic         dout_oe;
    logic [W-1:0] vin = '0;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // comparator model: input at or above the DAC code
    assign cmp_in = (dac_code <= vin);

    sar_adc_core #(
        .WIDTH(W), .OVERHEAD_CYCLES(OVH), .STEP_CYCLES(STEP), .WAKE_CYCLES(WAKE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .shutdown_n(shutdown_n), .cs_n(cs_n),
        .sclk(sclk), .cmp_in(cmp_in), .dac_code(dac_code), .dout(dout),
        .dout_oe(dout_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    // start a conversion of value v and wait for the end-of-conversion flag
    task automatic convert(input int v, input bit wiggle);
        int  lat;
        bit  seen;
        vin  = W'(v);
        sclk = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        lat  = 0;
        seen = 0;
        while (!seen && lat < CONV + 20) begin
            if (wiggle) sclk = lat[0];
            @(negedge clk);
            lat++;
            if (lat == 1) begin
                chk(dout_oe == 1'b1, "R3 oe", int'(dout_oe), 1);
                chk(dout == 1'b0, "R3 dout", int'(dout), 0);
            end
            if (dout_oe && dout) seen = 1;
        end
        chk(lat == CONV + 1, "R4 latency", lat, CONV + 1);
        chk(dac_code == W'(v), "R5 code", int'(dac_code), v);
        sclk = 1'b1;
        @(negedge clk);
        chk(dout == 1'b1, "R11 eoc held", int'(dout), 1);
    endtask

    // shift out the result; optional early release after nbits
    task automatic readout(input int v, input int nbits);
        logic [W-1:0] bits;
        bits = W'(v);
        for (int k = 0; k < nbits; k++) begin
            sclk = 1'b0;
            @(negedge clk);
            chk(dout == bits[W-1-k], "R6 bit", int'(dout), int'(bits[W-1-k]));
            @(negedge clk);
            chk(dout == bits[W-1-k], "R8 hold", int'(dout), int'(bits[W-1-k]));
            sclk = 1'b1;
            @(negedge clk);
        end
        if (nbits == W) begin
            sclk = 1'b0;
            @(negedge clk);
            chk(dout == 1'b0, "R7 tail", int'(dout), 0);
            sclk = 1'b1;
            @(negedge clk);
        end
        cs_n = 1'b1;
        @(negedge clk);
        chk(dout_oe == 1'b0, "R9 release", int'(dout_oe), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        wait_n(3);
        chk(dout_oe == 1'b0, "R1 reset oe", int'(dout_oe), 0);
        chk(dac_code == '0, "R1 reset code", int'(dac_code), 0);
        rst_n = 1'b1;
        wait_n(WAKE + 3);

        // exhaustive sweep over every input code
        for (int v = 0; v < (1 << W); v++) begin
            convert(v, v[0]);
            readout(v, W);
        end

        // abort during conversion
        vin = W'(45);
        cs_n = 1'b0;
        wait_n(5);
        cs_n = 1'b1;
        @(negedge clk);
        chk(dout_oe == 1'b0, "R10 abort conv", int'(dout_oe), 0);
        wait_n(2);
        convert(22, 0);
        readout(22, W);

        // abort during readout
        convert(51, 0);
        readout(51, 2);
        wait_n(2);
        convert(13, 1);
        readout(13, W);

        // shutdown holds the block off
        shutdown_n = 1'b0;
        @(negedge clk);
        chk(dout_oe == 1'b0, "R1 shutdown oe", int'(dout_oe), 0);
        cs_n = 1'b0;
        for (int i = 0; i < CONV + 4; i++) begin
            @(negedge clk);
            chk(dout_oe == 1'b0, "R1 cs ignored", int'(dout_oe), 0);
        end
        cs_n = 1'b1;
        @(negedge clk);

        // wake-up boundary: fall at WAKE ignored, at WAKE+1 honoured
        for (int k = WAKE; k <= WAKE + 1; k++) begin
            shutdown_n = 1'b0;
            wait_n(2);
            shutdown_n = 1'b1;
            wait_n(k);
            cs_n = 1'b0;
            wait_n(3);
            chk(dout_oe == (k > WAKE), "R2 wake boundary", int'(dout_oe), int'(k > WAKE));
            cs_n = 1'b1;
            wait_n(2);
        end
        convert(37, 0);
        readout(37, W);

        finish_run();
    end

endmodule